// File: doc/BRIEF.md
# Ultra DMA Control-Line Function Multiplexer

This host-side block gives new meanings to three shared ATA control lines while an Ultra DMA burst is in progress and gives the old meanings back once the burst ends. The burst-active input stands for the host's DMA acknowledge. The direction is taken when a burst starts. Between bursts the two host-driven strobe lines rest negated. The ready line from the drive then serves as the programmed-I/O wait signal.

During a burst, the read-strobe line carries one of two host signals. In a data-in burst it carries the host's DMA-ready. In a data-out burst it carries the host's data strobe. The write-strobe line carries the host's stop request in both directions. The ready line from the drive is synchronised first. It is then sent out as the drive data strobe in data-in bursts and as the drive DMA-ready in data-out bursts.

While a data-out burst runs, the block keeps a running CRC over the words sent. A one-cycle flag marks the point at which the CRC is final and can go to the drive. The block assumes it is clocked at 66 MHz or faster for mode-2 timing. Burst timing, data FIFOs and registers are outside it.

Top module: `udma_pin_mux`

## Requirements
- R1: When `burst_act_i` was low at the previous clock edge, `dior_o` and `diow_o` are both 1 (negated).
- R2: In a data-in burst, `dior_o` equals the `host_ready_i` value sampled at the previous clock edge.
- R3: In a data-out burst, `dior_o` equals the `host_strobe_i` value sampled at the previous clock edge.
- R4: While `burst_act_i` was high at the previous clock edge, `diow_o` equals the `host_stop_i` value sampled at that edge.
- R5: The burst direction is `dir_out_i` (1 = data-out, 0 = data-in) taken at the edge where `burst_act_i` is first seen high. Changes to `dir_out_i` later in the same burst have no effect.
- R6: `iordy_i` passes through `SYNC_STAGES` flip-flops, which reset to 1. The synchronised value appears on `drv_strobe_o` in data-in bursts and on `drv_ready_o` in data-out bursts. When no burst is active, its inverse appears on `pio_wait_o`. Each of these outputs is 0 outside its own mode.
- R7: At the edge where a burst starts, `crc_o` is loaded with the seed 16'h4ABA. Reset also loads this seed.
- R8: In a data-out burst, each edge with `burst_act_i` and `word_valid_i` high advances `crc_o` by one 16-bit `word_i`. The update uses polynomial 16'h1021 (x^16+x^12+x^5+1), processes the word MSB first, and neither reflects nor inverts. The start edge itself does not update the CRC.
- R9: `crc_done_o` is high for exactly one cycle, following the edge at which `burst_act_i` is seen low after a data-out burst. `crc_o` then holds its value until the next burst starts.
- R10: `pin_oe_o` is 0 while reset is held and 1 from the first clock edge after reset is released.
- R11: Words offered during data-in bursts or between bursts leave `crc_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| burst_act_i | input | 1 | Ultra DMA burst in progress (DMA acknowledge asserted) |
| dir_out_i | input | 1 | Burst direction, 1 = data-out |
| host_strobe_i | input | 1 | Host data strobe level for data-out bursts |
| host_ready_i | input | 1 | Host DMA-ready level for data-in bursts |
| host_stop_i | input | 1 | Host stop request |
| word_valid_i | input | 1 | A data-out word is transferred this cycle |
| word_i | input | 16 | Data-out word |
| iordy_i | input | 1 | Ready line from the drive (asynchronous) |
| dior_o | output | 1 | Read-strobe line value |
| diow_o | output | 1 | Write-strobe line value |
| pin_oe_o | output | 1 | Output enable for the two strobe lines |
| drv_strobe_o | output | 1 | Drive data strobe, data-in bursts |
| drv_ready_o | output | 1 | Drive DMA-ready, data-out bursts |
| pio_wait_o | output | 1 | PIO wait request between bursts |
| crc_o | output | 16 | Running/final burst CRC |
| crc_done_o | output | 1 | One-cycle pulse: CRC final after a data-out burst |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 rather than the default 2. This checks that the delay through the synchronising chain follows the parameter. It also makes sure that toggles on the ready line cross a change of mode while they are still inside the chain. The CRC width and polynomial keep their defaults, so the seed and update values can be checked against a bench CRC function. Random bursts of mixed direction and length, including one-cycle bursts and back-to-back bursts, reach the start, stop and direction-hold corners.

// File: rtl/udma_pkg.sv
`timescale 1ns/1ps
// Shared types for the Ultra DMA line multiplexer.
// Assumes: one burst direction per burst, chosen at burst start.
package udma_pkg;
    typedef enum logic [1:0] {
        UM_IDLE = 2'd0,
        UM_IN   = 2'd1,
        UM_OUT  = 2'd2
    } udma_mode_e;
endpackage

// File: rtl/udma_mode_ctrl.sv
`timescale 1ns/1ps
// Burst mode register and registered strobe-line drivers.
// Latches the burst direction at burst start and holds it for the whole burst.
// The line values and the output enable come only from flip-flops, so no
// combinational path reaches the shared lines across a mode change.
// Assumes burst_act_i and the host controls are synchronous to clk.
module udma_mode_ctrl
    import udma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       burst_act_i,
    input  logic       dir_out_i,
    input  logic       host_strobe_i,
    input  logic       host_ready_i,
    input  logic       host_stop_i,
    output udma_mode_e mode_o,
    output logic       dior_o,
    output logic       diow_o,
    output logic       pin_oe_o
);
    udma_mode_e mode_q, mode_d;
    logic       dior_d, diow_d;
    logic       dior_q, diow_q, oe_q;

    // Next mode: direction taken only on the start edge, dropped when the burst ends.
    always_comb begin
        if (!burst_act_i)
            mode_d = UM_IDLE;
        else if (mode_q == UM_IDLE)
            mode_d = dir_out_i ? UM_OUT : UM_IN;
        else
            mode_d = mode_q;
    end

    // Next line values, chosen by the mode that will hold after this edge.
    always_comb begin
        unique case (mode_d)
            UM_IN: begin
                dior_d = host_ready_i;
                diow_d = host_stop_i;
            end
            UM_OUT: begin
                dior_d = host_strobe_i;
                diow_d = host_stop_i;
            end
            default: begin
                dior_d = 1'b1;
                diow_d = 1'b1;
            end
        endcase
    end

    // Mode, line and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= UM_IDLE;
            dior_q <= 1'b1;
            diow_q <= 1'b1;
            oe_q   <= 1'b0;
        end else begin
            mode_q <= mode_d;
            dior_q <= dior_d;
            diow_q <= diow_d;
            oe_q   <= 1'b1;
        end
    end

    assign mode_o   = mode_q;
    assign dior_o   = dior_q;
    assign diow_o   = diow_q;
    assign pin_oe_o = oe_q;

    AST_IDLE_NEGATED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(burst_act_i)) |-> (dior_q && diow_q)); // R1
    AST_DIN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode_q == UM_IN) |-> (dior_q == $past(host_ready_i))); // R2
    AST_DOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode_q == UM_OUT) |-> (dior_q == $past(host_strobe_i))); // R3
    AST_STOP_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(burst_act_i)) |-> (diow_q == $past(host_stop_i))); // R4
    AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != UM_IDLE && burst_act_i) |=> (mode_q == $past(mode_q))); // R5
    AST_OE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> oe_q); // R10
endmodule

// File: rtl/udma_iordy_demux.sv
`timescale 1ns/1ps
// Synchronises the drive's ready line and routes it by burst mode:
// drive strobe in data-in bursts, drive ready in data-out bursts,
// inverted PIO wait between bursts. Every output is 0 outside its mode.
// Assumes SYNC_STAGES >= 1. The chain resets to 1, meaning "not waiting".
module udma_iordy_demux
    import udma_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       iordy_i,
    input  udma_mode_e mode_i,
    output logic       drv_strobe_o,
    output logic       drv_ready_o,
    output logic       pio_wait_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   line_s;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= iordy_i;
            end
        end else begin : g_chain
            // Shift chain, the newest sample enters at bit 0.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], iordy_i};
            end
        end
    endgenerate

    assign line_s = sync_q[LAST];

    // Route the synchronised line to the output belonging to the current mode.
    always_comb begin
        drv_strobe_o = 1'b0;
        drv_ready_o  = 1'b0;
        pio_wait_o   = 1'b0;
        unique case (mode_i)
            UM_IN:   drv_strobe_o = line_s;
            UM_OUT:  drv_ready_o  = line_s;
            default: pio_wait_o   = ~line_s;
        endcase
    end

    AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drv_strobe_o, drv_ready_o, pio_wait_o})); // R6
endmodule

// File: rtl/udma_crc_acc.sv
`timescale 1ns/1ps
// Running CRC over the words of a data-out burst.
// Seeds at the burst start edge and updates once per valid word while a
// data-out burst continues. Pulses done for one cycle after a data-out burst
// ends, and holds the result until the next burst starts.
// Assumes the word is processed MSB first, with no reflection or final inversion.
module udma_crc_acc
    import udma_pkg::*;
#(
    parameter int                CRC_W  = 16,
    parameter int                WORD_W = 16,
    parameter logic [CRC_W-1:0]  POLY   = 16'h1021,
    parameter logic [CRC_W-1:0]  SEED   = 16'h4ABA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  udma_mode_e        mode_i,
    input  logic              burst_act_i,
    input  logic              word_valid_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [CRC_W-1:0]  crc_o,
    output logic              done_o
);
    logic [CRC_W-1:0] crc_q;
    logic             done_q;
    logic             start_w, upd_w, end_w;

    // One word through the serial CRC, unrolled over WORD_W bits.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [WORD_W-1:0] d);
        logic [CRC_W-1:0] r;
        logic             fb;
        r = c;
        for (int b = WORD_W - 1; b >= 0; b--) begin
            fb = r[CRC_W-1] ^ d[b];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ POLY;
        end
        return r;
    endfunction

    assign start_w = (mode_i == UM_IDLE) && burst_act_i;
    assign upd_w   = (mode_i == UM_OUT) && burst_act_i && word_valid_i;
    assign end_w   = (mode_i == UM_OUT) && !burst_act_i;

    // CRC register: seed, update or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       crc_q <= SEED;
        else if (start_w) crc_q <= SEED;
        else if (upd_w)   crc_q <= crc_step(crc_q, word_i);
    end

    // End-of-data-out-burst pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= end_w;
    end

    assign crc_o  = crc_q;
    assign done_o = done_q;

    AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> (crc_q == SEED)); // R7
    AST_CRC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != UM_OUT && !burst_act_i) |=> $stable(crc_q)); // R11
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R9
endmodule

// File: rtl/udma_pin_mux.sv
`timescale 1ns/1ps
// Ultra DMA control-line multiplexer, top level.
// Gives the read-strobe, write-strobe and ready lines their burst meanings
// while burst_act_i is high, puts back the PIO meanings when it drops, and
// keeps the data-out burst CRC. Assumes a clock of 66 MHz or more for
// mode-2 bursts. Burst timing is produced outside this block.
module udma_pin_mux
    import udma_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter int               WORD_W      = 16,
    parameter int               CRC_W       = 16,
    parameter logic [CRC_W-1:0] CRC_POLY    = 16'h1021,
    parameter logic [CRC_W-1:0] CRC_SEED    = 16'h4ABA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_act_i,
    input  logic              dir_out_i,
    input  logic              host_strobe_i,
    input  logic              host_ready_i,
    input  logic              host_stop_i,
    input  logic              word_valid_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              iordy_i,
    output logic              dior_o,
    output logic              diow_o,
    output logic              pin_oe_o,
    output logic              drv_strobe_o,
    output logic              drv_ready_o,
    output logic              pio_wait_o,
    output logic [CRC_W-1:0]  crc_o,
    output logic              crc_done_o
);
    udma_mode_e mode_w;

    udma_mode_ctrl u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .burst_act_i   (burst_act_i),
        .dir_out_i     (dir_out_i),
        .host_strobe_i (host_strobe_i),
        .host_ready_i  (host_ready_i),
        .host_stop_i   (host_stop_i),
        .mode_o        (mode_w),
        .dior_o        (dior_o),
        .diow_o        (diow_o),
        .pin_oe_o      (pin_oe_o)
    );

    udma_iordy_demux #(.SYNC_STAGES(SYNC_STAGES)) u_rdy (
        .clk          (clk),
        .rst_n        (rst_n),
        .iordy_i      (iordy_i),
        .mode_i       (mode_w),
        .drv_strobe_o (drv_strobe_o),
        .drv_ready_o  (drv_ready_o),
        .pio_wait_o   (pio_wait_o)
    );

    udma_crc_acc #(
        .CRC_W  (CRC_W),
        .WORD_W (WORD_W),
        .POLY   (CRC_POLY),
        .SEED   (CRC_SEED)
    ) u_crc (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode_w),
        .burst_act_i  (burst_act_i),
        .word_valid_i (word_valid_i),
        .word_i       (word_i),
        .crc_o        (crc_o),
        .done_o       (crc_done_o)
    );

    AST_DONE_AFTER_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        crc_done_o |-> ($past(mode_w) == UM_OUT && !$past(burst_act_i))); // R9
endmodule

// File: tb/udma_pin_mux_bench.sv
`timescale 1ns/1ps
module udma_pin_mux_bench;
    localparam int          SYNC = 3;
    localparam logic [15:0] SEED = 16'h4ABA;
    localparam logic [15:0] POLY = 16'h1021;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        act = 0, dir = 0, stb = 0, rdy = 0, stp = 0, wv = 0, io = 1;
    logic [15:0] w = '0;
    logic        dior, diow, oe, dstb, drdy, pwait, done;
    logic [15:0] crc;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // Bench model state
    int          m_mode = 0;           // 0 idle, 1 data-in, 2 data-out
    logic [15:0] m_crc = SEED;
    logic        m_done = 0, m_dior = 1, m_diow = 1, m_oe = 0;
    logic [SYNC-1:0] m_sync = '1;
    string       crc_tag = "R7";

    always #2.5 clk = ~clk;

    udma_pin_mux #(.SYNC_STAGES(SYNC)) u_udma_pin_mux (
        .clk(clk), .rst_n(rst_n), .burst_act_i(act), .dir_out_i(dir),
        .host_strobe_i(stb), .host_ready_i(rdy), .host_stop_i(stp),
        .word_valid_i(wv), .word_i(w), .iordy_i(io),
        .dior_o(dior), .diow_o(diow), .pin_oe_o(oe),
        .drv_strobe_o(dstb), .drv_ready_o(drdy), .pio_wait_o(pwait),
        .crc_o(crc), .crc_done_o(done)
    );

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] d);
        logic [15:0] r = c;
        for (int b = 15; b >= 0; b--) begin
            logic fb = r[15] ^ d[b];
            r = {r[14:0], 1'b0};
            if (fb) r = r ^ POLY;
        end
        return r;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, got, exp, $time);
        end
    endtask

    // Advance the model by one clock edge using the values now on the inputs.
    task automatic model_edge();
        int nm;
        nm = !act ? 0 : (m_mode == 0 ? (dir ? 2 : 1) : m_mode);
        if (m_mode == 0 && act) begin
            m_crc = SEED; crc_tag = "R7";
        end else if (m_mode == 2 && act && wv) begin
            m_crc = ref_crc(m_crc, w); crc_tag = "R8";
        end else begin
            crc_tag = (m_mode == 2 && act) ? "R8" : (m_mode == 2 ? "R9" : "R11");
        end
        m_done = (m_mode == 2 && !act);
        m_dior = (nm == 0) ? 1'b1 : (nm == 1 ? rdy : stb);
        m_diow = (nm == 0) ? 1'b1 : stp;
        m_oe   = 1'b1;
        m_sync = {m_sync[SYNC-2:0], io};
        m_mode = nm;
    endtask

    task automatic compare_all();
        logic s = m_sync[SYNC-1];
        chk(m_mode == 0 ? "R1" : (m_mode == 1 ? "R2" : "R3"), "dior", 16'(dior), 16'(m_dior));
        chk(m_mode == 0 ? "R1" : "R4", "diow", 16'(diow), 16'(m_diow));
        chk("R10", "pin_oe", 16'(oe), 16'(m_oe));
        chk("R6", "drv_strobe", 16'(dstb), 16'(m_mode == 1 && s));
        chk("R6", "drv_ready", 16'(drdy), 16'(m_mode == 2 && s));
        chk("R6", "pio_wait", 16'(pwait), 16'(m_mode == 0 && !s));
        chk(crc_tag, "crc", crc, m_crc);
        chk("R9", "crc_done", 16'(done), 16'(m_done));
    endtask

    // Drive at the falling edge, let the rising edge pass, then compare.
    task automatic step(input logic a, input logic d, input logic s, input logic r,
                        input logic p, input logic v, input logic [15:0] wd, input logic i);
        @(negedge clk);
        act = a; dir = d; stb = s; rdy = r; stp = p; wv = v; w = wd; io = i;
        @(posedge clk);
        model_edge();
        #1;
        compare_all();
    endtask

    task automatic rand_step(input logic a, input logic d);
        step(a, d, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             16'($urandom), 1'($urandom));
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int unused_seed;
        unused_seed = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        #1;
        // Reset state
        chk("R10", "pin_oe in reset", 16'(oe), 16'h0);
        chk("R1", "dior in reset", 16'(dior), 16'h1);
        chk("R1", "diow in reset", 16'(diow), 16'h1);
        chk("R7", "crc in reset", crc, SEED);
        chk("R9", "done in reset", 16'(done), 16'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Idle: ready line becomes PIO wait after SYNC edges (R6); words ignored (R11)
        step(0, 0, 0, 0, 0, 1, 16'h1234, 0);
        step(0, 1, 1, 1, 0, 1, 16'hFFFF, 0);
        step(0, 0, 0, 0, 1, 1, 16'h0001, 0);
        step(0, 0, 0, 0, 0, 0, 16'h0000, 1);
        chk("R11", "crc untouched while idle", crc, SEED);

        // Directed data-out burst of fixed words (R3, R4, R7, R8)
        step(1, 1, 1, 0, 0, 1, 16'hAAAA, 1);
        for (int k = 0; k < 8; k++) step(1, 1, k[0], 0, 0, 1, 16'(k * 16'h1111), 1);
        step(1, 1, 0, 0, 1, 0, 16'h0, 1);
        step(0, 1, 0, 0, 0, 0, 16'h0, 1);
        chk("R9", "done pulse after data-out", 16'(done), 16'h1);
        step(0, 0, 0, 0, 0, 1, 16'h5555, 1);
        chk("R9", "done falls, crc held", 16'(done), 16'h0);

        // Data-in burst with direction flipped mid-burst (R2, R5, R11)
        step(1, 0, 0, 1, 0, 1, 16'h7777, 0);
        step(1, 1, 1, 0, 0, 1, 16'h8888, 1);
        chk("R5", "dior follows ready after flip", 16'(dior), 16'h0);
        step(1, 1, 0, 1, 0, 1, 16'h9999, 0);
        chk("R5", "dior follows ready after flip", 16'(dior), 16'h1);
        step(0, 0, 0, 0, 0, 0, 16'h0, 1);
        chk("R11", "crc after data-in holds seed", crc, SEED);

        // One-cycle data-out burst: seed, then done (R7, R9)
        step(1, 1, 0, 0, 0, 1, 16'hBEEF, 1);
        step(0, 1, 0, 0, 0, 1, 16'hBEEF, 1);
        chk("R9", "short burst done", 16'(done), 16'h1);
        chk("R7", "short burst crc is seed", crc, SEED);

        // Random bursts, including back-to-back restarts
        for (int b = 0; b < 300; b++) begin
            logic d = 1'($urandom);
            int len = int'($urandom_range(1, 20));
            for (int k = 0; k < len; k++) rand_step(1, (k == 0) ? d : 1'($urandom));
            for (int g = int'($urandom_range(1, 4)); g > 0; g--) rand_step(0, 1'($urandom));
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule